// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the shift stage in front of a 32-bit RISC ALU. It takes one operand, a shift amount, a 3-bit shift-kind code and the present carry flag. It returns the shifted operand and the carry-out that the flag logic should latch.

Five kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry. Only the low byte of the amount field is used. Amounts of zero, exactly the word width, and larger than the word width each have their own defined result and carry.

The arithmetic is purely combinational. An output register stage, selected by a parameter and on by default, lets the block close timing in a long operand path. The register has a synchronous active-low reset.

Top module: `barrel_carry_shifter`

## Requirements
- R1: The shift-kind codes are 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right and 4 = rotate right through carry. For logical left by n in 1..32, the result is the operand shifted left by n with zeros filled in. The carry is operand bit (32-n), so a shift by 32 gives result 0 and carry equal to operand bit 0.
- R2: Only bits [7:0] of the amount input are used. Any value in the higher bits leaves the result and the carry unchanged.
- R3: For kinds 0 to 3 with an amount of zero, the result equals the operand and the carry-out equals the incoming carry.
- R4: For logical right by n in 1..32, the result is the operand shifted right with zeros filled in, and the carry is operand bit (n-1).
- R5: For logical left or logical right by more than 32, the result is zero and the carry is zero.
- R6: For arithmetic right by n in 1..31, the vacated bits are filled with operand bit 31 and the carry is operand bit (n-1). For n of 32 or more, every result bit and the carry equal operand bit 31.
- R7: For rotate right by a nonzero amount, the operand is rotated by the amount modulo 32 and the carry equals result bit 31. A nonzero multiple of 32 therefore returns the operand with carry equal to operand bit 31.
- R8: Rotate through carry ignores the amount. The result is {incoming carry, operand[31:1]} and the carry-out is operand bit 0.
- R9: For kind codes 5, 6 and 7, the result equals the operand and the carry-out equals the incoming carry.
- R10: With the output register enabled, the outputs reflect the inputs sampled at the previous rising clock edge. A clock edge with reset low clears the result and the carry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_in | input | 32 | Operand to shift |
| amt_in | input | 16 | Shift amount; only bits [7:0] are used |
| kind_in | input | 3 | Shift-kind code |
| carry_in | input | 1 | Present carry flag |
| res_out | output | 32 | Shifted result |
| carry_out | output | 1 | Carry-out flag |

## Verification
The bench targets the amount boundaries where shifters usually go wrong:
- **Exactly 32 on a left shift.** A design that reduces the amount modulo 32 returns the operand unshifted.
- **33 and above on logical shifts.** A design that lets stray bits survive returns nonzero data or a stale carry.
- **Arithmetic right with a large amount.** A design that clamps incorrectly drops the sign fill.
- **Rotate by 32 or 64.** Mishandling turns these into a no-op that passes the incoming carry instead of bit 31.
- **Zero amount.** A design that computes a carry anyway overwrites the flag that should pass through.
- **High amount bits, the one-bit carry rotate and the unused codes.** A wide comparison on the amount, a swapped carry source, or a default arm that zeroes the output would each show here.

// File: rtl/bsc_pkg.sv
// Package: shared shift-kind codes and widths for the barrel shifter.
// Assumes the code values are fixed by the instruction decoder upstream.
package bsc_pkg;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRC = 3'd4
    } shift_kind_e;

    localparam int unsigned KIND_W     = 3;
    localparam int unsigned AMT_FIELD  = 8;

endpackage

// File: rtl/bsc_amount_class.sv
// Amount classifier: keeps the used low field of the amount and flags zero.
// Assumes AMT_W is wide enough to hold DATA_W plus one.
module bsc_amount_class #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AMT_W  = 8,
    localparam int unsigned ROT_W = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0] amt_field,
    output logic [AMT_W-1:0] amt,
    output logic [ROT_W-1:0] rot_amt,
    output logic             amt_zero
);

    // purpose: expose the amount, its rotate residue and the zero flag
    always_comb begin
        amt      = amt_field;
        rot_amt  = amt_field[ROT_W-1:0];
        amt_zero = (amt_field == '0);
    end

endmodule

// File: rtl/bsc_shift_unit.sv
// Shift unit: computes result and carry-out for every shift kind.
// Purely combinational.
// Assumes the amount is already reduced to the used field.
module bsc_shift_unit
    import bsc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AMT_W  = 8,
    localparam int unsigned ROT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] op,
    input  logic [AMT_W-1:0]  amt,
    input  logic [ROT_W-1:0]  rot_amt,
    input  logic              amt_zero,
    input  logic [KIND_W-1:0] kind,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    logic [DATA_W:0]          lsl_ext;
    logic [DATA_W:0]          lsr_ext;
    logic signed [DATA_W:0]   asr_src;
    logic [DATA_W:0]          asr_ext;
    logic [2*DATA_W-1:0]      dbl;
    logic [DATA_W-1:0]        ror_res;

    // purpose: extended shifts; the extra bit carries the last bit shifted out
    always_comb begin
        lsl_ext = {1'b0, op} << amt;
        lsr_ext = {op, 1'b0} >> amt;
        asr_src = {op, 1'b0};
        asr_ext = asr_src >>> amt;
        dbl     = {op, op};
        ror_res = dbl[rot_amt +: DATA_W];
    end

    // purpose: select result and carry per kind, including zero-amount pass-through
    always_comb begin
        res  = op;
        cout = cin;
        unique case (kind)
            SK_LSL: if (!amt_zero) begin
                res  = lsl_ext[DATA_W-1:0];
                cout = lsl_ext[DATA_W];
            end
            SK_LSR: if (!amt_zero) begin
                res  = lsr_ext[DATA_W:1];
                cout = lsr_ext[0];
            end
            SK_ASR: if (!amt_zero) begin
                res  = asr_ext[DATA_W:1];
                cout = asr_ext[0];
            end
            SK_ROR: if (!amt_zero) begin
                res  = ror_res;
                cout = ror_res[DATA_W-1];
            end
            SK_RRC: begin
                res  = {cin, op[DATA_W-1:1]};
                cout = op[0];
            end
            default: begin
                res  = op;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/bsc_out_stage.sv
// Output stage: a register with synchronous active-low reset, or a plain
// pass-through, as selected by OUT_REG.
module bsc_out_stage #(
    parameter int unsigned DATA_W  = 32,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_d,
    input  logic              cout_d,
    output logic [DATA_W-1:0] res_q,
    output logic              cout_q
);

    generate
        if (OUT_REG) begin : g_reg
            // purpose: register result and carry; reset clears both
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q  <= '0;
                    cout_q <= 1'b0;
                end else begin
                    res_q  <= res_d;
                    cout_q <= cout_d;
                end
            end
        end else begin : g_wire
            // purpose: combinational pass-through when no register is wanted
            always_comb begin
                res_q  = res_d;
                cout_q = cout_d;
            end
        end
    endgenerate

endmodule

// File: rtl/barrel_carry_shifter.sv
// Top: barrel shifter with flag-accurate carry-out for the operand stage.
// Assumes AMT_IN_W >= AMT_W.
// Only the low AMT_W bits of the amount are used.
module barrel_carry_shifter
    import bsc_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned AMT_IN_W = 16,
    parameter int unsigned AMT_W    = AMT_FIELD,
    parameter bit          OUT_REG  = 1'b1,
    localparam int unsigned ROT_W   = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   op_in,
    input  logic [AMT_IN_W-1:0] amt_in,
    input  logic [KIND_W-1:0]   kind_in,
    input  logic                carry_in,
    output logic [DATA_W-1:0]   res_out,
    output logic                carry_out
);

    logic [AMT_W-1:0]  amt_field;
    logic [AMT_W-1:0]  amt;
    logic [ROT_W-1:0]  rot_amt;
    logic              amt_zero;
    logic [DATA_W-1:0] res_c;
    logic              cout_c;

    // purpose: drop the amount bits above the used field
    assign amt_field = amt_in[AMT_W-1:0];

    bsc_amount_class #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt (
        .amt_field (amt_field),
        .amt       (amt),
        .rot_amt   (rot_amt),
        .amt_zero  (amt_zero)
    );

    bsc_shift_unit #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
        .op       (op_in),
        .amt      (amt),
        .rot_amt  (rot_amt),
        .amt_zero (amt_zero),
        .kind     (kind_in),
        .cin      (carry_in),
        .res      (res_c),
        .cout     (cout_c)
    );

    bsc_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .res_d  (res_c),
        .cout_d (cout_c),
        .res_q  (res_out),
        .cout_q (carry_out)
    );

endmodule

// File: rtl/bsc_checker.sv
// Checker: properties relating the shifter outputs to the inputs of the cycle
// they belong to. It keeps its own copy of the inputs when the output is registered.
module bsc_checker #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned AMT_IN_W = 16,
    parameter int unsigned AMT_W    = 8,
    parameter bit          OUT_REG  = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DATA_W-1:0]   op_in,
    input logic [AMT_IN_W-1:0] amt_in,
    input logic [2:0]          kind_in,
    input logic                carry_in,
    input logic [DATA_W-1:0]   res_out,
    input logic                carry_out
);

    logic [DATA_W-1:0] op_q,   s_op;
    logic [AMT_W-1:0]  amt_q,  s_amt;
    logic [2:0]        kind_q, s_kind;
    logic              cin_q,  s_cin;
    logic              vld_q,  s_vld;

    // purpose: capture the inputs that the registered outputs belong to
    always_ff @(posedge clk) begin
        op_q   <= op_in;
        amt_q  <= amt_in[AMT_W-1:0];
        kind_q <= kind_in;
        cin_q  <= carry_in;
        vld_q  <= rst_n;
    end

    // purpose: choose live or captured inputs according to the latency
    always_comb begin
        s_op   = OUT_REG ? op_q   : op_in;
        s_amt  = OUT_REG ? amt_q  : amt_in[AMT_W-1:0];
        s_kind = OUT_REG ? kind_q : kind_in;
        s_cin  = OUT_REG ? cin_q  : carry_in;
        s_vld  = OUT_REG ? vld_q  : 1'b1;
    end

    p_zero_amount_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_kind <= 3'd3 && s_amt == '0) |-> (res_out == s_op && carry_out == s_cin));

    p_lsr_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_kind == 3'd1 && s_amt != '0 && s_amt <= AMT_W'(DATA_W))
        |-> (carry_out == s_op[s_amt - AMT_W'(1)]));

    p_logical_over_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && (s_kind == 3'd0 || s_kind == 3'd1) && s_amt > AMT_W'(DATA_W))
        |-> (res_out == '0 && !carry_out));

    p_asr_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_kind == 3'd2 && s_amt >= AMT_W'(DATA_W))
        |-> (res_out == {DATA_W{s_op[DATA_W-1]}} && carry_out == s_op[DATA_W-1]));

    p_ror_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_kind == 3'd3 && s_amt != '0) |-> (carry_out == res_out[DATA_W-1]));

    p_rrc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_kind == 3'd4) |-> (res_out == {s_cin, s_op[DATA_W-1:1]} && carry_out == s_op[0]));

    p_spare_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_kind >= 3'd5) |-> (res_out == s_op && carry_out == s_cin));

    p_reset_clear_r10: assert property (@(posedge clk)
        (OUT_REG && vld_q == 1'b0 && $past(rst_n) == 1'b0) |-> (res_out == '0 && !carry_out));

endmodule

bind barrel_carry_shifter bsc_checker #(
    .DATA_W(DATA_W), .AMT_IN_W(AMT_IN_W), .AMT_W(AMT_W), .OUT_REG(OUT_REG)
) u_bsc_checker (
    .clk(clk), .rst_n(rst_n), .op_in(op_in), .amt_in(amt_in), .kind_in(kind_in),
    .carry_in(carry_in), .res_out(res_out), .carry_out(carry_out)
);

// File: tb/test_barrel_carry_shifter.sv
`timescale 1ns/1ps
module test_barrel_carry_shifter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_in = '0;
    logic [15:0] amt_in = '0;
    logic [2:0]  kind_in = '0;
    logic        carry_in = 1'b0;
    logic [31:0] res_out;
    logic        carry_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    barrel_carry_shifter i_barrel_carry_shifter (
        .clk(clk), .rst_n(rst_n), .op_in(op_in), .amt_in(amt_in),
        .kind_in(kind_in), .carry_in(carry_in), .res_out(res_out), .carry_out(carry_out)
    );

    // bit-serial reference model built from the requirements
    function automatic logic [32:0] model(input logic [31:0] op, input logic [15:0] a16,
                                          input logic [2:0] k, input logic ci);
        logic [7:0]  a;
        logic [31:0] r;
        logic        c;
        a = a16[7:0];
        r = op;
        c = ci;
        case (k)
            3'd0: for (int i = 0; i < int'(a); i++) begin c = r[31]; r = r << 1; end
            3'd1: for (int i = 0; i < int'(a); i++) begin c = r[0]; r = r >> 1; end
            3'd2: for (int i = 0; i < int'(a); i++) begin c = r[0]; r = {r[31], r[31:1]}; end
            3'd3: if (a != 0) begin
                for (int i = 0; i < int'(a); i++) r = {r[0], r[31:1]};
                c = r[31];
            end
            3'd4: begin c = op[0]; r = {ci, op[31:1]}; end
            default: ;
        endcase
        return {c, r};
    endfunction

    task automatic compare(input string tag, input logic [31:0] er, input logic ec);
        n_chk++;
        if (res_out !== er || carry_out !== ec) begin
            n_fail++;
            $display("FAIL %s: got res=%h c=%b expected res=%h c=%b", tag, res_out, carry_out, er, ec);
        end
    endtask

    // drive at a falling edge, check one clock later (one register stage)
    task automatic apply(input string tag, input logic [31:0] op, input logic [15:0] a,
                         input logic [2:0] k, input logic ci);
        logic [32:0] e;
        @(negedge clk);
        op_in = op; amt_in = a; kind_in = k; carry_in = ci;
        e = model(op, a, k, ci);
        @(negedge clk);
        compare(tag, e[31:0], e[32]);
    endtask

    task automatic t_reset;
        op_in = 32'hFFFF_FFFF; amt_in = 16'd3; kind_in = 3'd1; carry_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R10 reset", 32'h0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_lsl;
        apply("R1 lsl1",  32'h8000_0001, 16'd1,  3'd0, 1'b0);
        apply("R1 lsl31", 32'h8000_0003, 16'd31, 3'd0, 1'b0);
        apply("R1 lsl32", 32'h8000_0001, 16'd32, 3'd0, 1'b0);
        compare("R1 lsl32 const", 32'h0, 1'b1);
        apply("R1 lsl4",  32'h1234_5678, 16'd4,  3'd0, 1'b1);
        compare("R1 lsl4 const", 32'h2345_6780, 1'b1);
    endtask

    task automatic t_lsr;
        apply("R4 lsr1",  32'hA5A5_0F0F, 16'd1,  3'd1, 1'b0);
        apply("R4 lsr4",  32'hA5A5_0F08, 16'd4,  3'd1, 1'b1);
        compare("R4 lsr4 const", 32'h0A5A_50F0, 1'b1);
        apply("R4 lsr32", 32'h8000_0000, 16'd32, 3'd1, 1'b0);
        compare("R4 lsr32 const", 32'h0, 1'b1);
    endtask

    task automatic t_over;
        apply("R5 lsl33",  32'hFFFF_FFFF, 16'd33,  3'd0, 1'b1);
        compare("R5 lsl33 const", 32'h0, 1'b0);
        apply("R5 lsr33",  32'hFFFF_FFFF, 16'd33,  3'd1, 1'b1);
        compare("R5 lsr33 const", 32'h0, 1'b0);
        apply("R5 lsl255", 32'hDEAD_BEEF, 16'd255, 3'd0, 1'b1);
        apply("R5 lsr200", 32'hDEAD_BEEF, 16'd200, 3'd1, 1'b1);
    endtask

    task automatic t_asr;
        apply("R6 asr4",   32'h8000_0010, 16'd4,   3'd2, 1'b0);
        compare("R6 asr4 const", 32'hF800_0001, 1'b0);
        apply("R6 asr31",  32'h4000_0000, 16'd31,  3'd2, 1'b1);
        apply("R6 asr32",  32'h8000_0000, 16'd32,  3'd2, 1'b0);
        compare("R6 asr32 const", 32'hFFFF_FFFF, 1'b1);
        apply("R6 asr33p", 32'h7FFF_FFFF, 16'd33,  3'd2, 1'b1);
        compare("R6 asr33p const", 32'h0, 1'b0);
        apply("R6 asr255", 32'h8000_0001, 16'd255, 3'd2, 1'b0);
    endtask

    task automatic t_ror;
        apply("R7 ror8",  32'h1234_56F8, 16'd8,  3'd3, 1'b0);
        compare("R7 ror8 const", 32'hF812_3456, 1'b1);
        apply("R7 ror31", 32'h8000_0001, 16'd31, 3'd3, 1'b0);
        apply("R7 ror32", 32'h8000_0000, 16'd32, 3'd3, 1'b0);
        compare("R7 ror32 const", 32'h8000_0000, 1'b1);
        apply("R7 ror64", 32'h0000_0001, 16'd64, 3'd3, 1'b1);
        compare("R7 ror64 const", 32'h0000_0001, 1'b0);
        apply("R7 ror33", 32'h0000_0001, 16'd33, 3'd3, 1'b0);
    endtask

    task automatic t_rrc;
        apply("R8 rrc c1", 32'h0000_0002, 16'd0,  3'd4, 1'b1);
        compare("R8 rrc c1 const", 32'h8000_0001, 1'b0);
        apply("R8 rrc c0", 32'hFFFF_FFFF, 16'd17, 3'd4, 1'b0);
        compare("R8 rrc c0 const", 32'h7FFF_FFFF, 1'b1);
    endtask

    task automatic t_zero;
        for (int k = 0; k < 4; k++) begin
            apply("R3 zero c1", 32'hC0DE_1234, 16'd0, 3'(k), 1'b1);
            compare("R3 zero c1 const", 32'hC0DE_1234, 1'b1);
            apply("R3 zero c0", 32'h8000_0001, 16'd0, 3'(k), 1'b0);
        end
    endtask

    task automatic t_mask;
        apply("R2 mask 0x0104", 32'h0000_00F0, 16'h0104, 3'd1, 1'b0);
        compare("R2 mask 0x0104 const", 32'h0000_000F, 1'b0);
        apply("R2 mask 0xFF00", 32'h1357_9BDF, 16'hFF00, 3'd0, 1'b1);
        compare("R2 mask 0xFF00 const", 32'h1357_9BDF, 1'b1);
        apply("R2 mask 0x8120", 32'h0000_0001, 16'h8120, 3'd3, 1'b1);
        compare("R2 mask 0x8120 const", 32'h0000_0001, 1'b0);
    endtask

    task automatic t_spare;
        for (int k = 5; k < 8; k++) begin
            apply("R9 spare", 32'hA1B2_C3D4, 16'd7, 3'(k), 1'b1);
            compare("R9 spare const", 32'hA1B2_C3D4, 1'b1);
        end
    endtask

    task automatic t_latency;
        logic [31:0] prev_r;
        logic        prev_c;
        @(negedge clk);
        prev_r = res_out; prev_c = carry_out;
        op_in = 32'h0F0F_0F0F; amt_in = 16'd4; kind_in = 3'd0; carry_in = 1'b0;
        #1;
        compare("R10 hold before edge", prev_r, prev_c);
        @(negedge clk);
        compare("R10 after edge", 32'hF0F0_F0F0, 1'b0);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] op;
            logic [15:0] a;
            logic [2:0]  k;
            op = $urandom;
            a  = 16'($urandom);
            if (i % 2 == 0) a[7:0] = 8'($urandom_range(0, 40));
            k  = 3'($urandom_range(0, 7));
            case (k)
                3'd0: apply("R1 sweep", op, a, k, 1'($urandom));
                3'd1: apply("R4 sweep", op, a, k, 1'($urandom));
                3'd2: apply("R6 sweep", op, a, k, 1'($urandom));
                3'd3: apply("R7 sweep", op, a, k, 1'($urandom));
                3'd4: apply("R8 sweep", op, a, k, 1'($urandom));
                default: apply("R9 sweep", op, a, k, 1'($urandom));
            endcase
        end
    endtask

    initial begin
        t_reset();
        t_lsl();
        t_lsr();
        t_over();
        t_asr();
        t_ror();
        t_rrc();
        t_zero();
        t_mask();
        t_spare();
        t_latency();
        t_sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got no completion expected completion before 100000 cycles");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule